// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a simple synchronous request port to a 16-bit asynchronous DRAM that supports fast page mode. A host presents a word address, a read or write flag, write data and two byte enables. The controller multiplexes the address onto a shared row/column bus. It drives the row strobe, two column strobes (one per byte lane), the write strobe and the output enable, and it moves data over a bidirectional bus. Every interval the DRAM needs is a parameter counted in clocks.

After an access the row stays open. A later request to the same row is served as a short column-only cycle, without another row activation. The row is closed, and the row strobe raised for precharge, in three cases: a request misses the open row, an external refresh scheduler asserts its grant, or the open time approaches the maximum row-active limit. Writes always use the early-write form: the write strobe falls before the column strobe. This keeps the DRAM's outputs off the bus for the whole write cycle.

Top module: `fpm_ctrl`

## Requirements
- R1: During and right after reset, every DRAM strobe is high, the data bus is not driven, `rsp_valid` is low and `req_ready` is low.
- R2: The row strobe falls with the word address bits above the column field on the address bus. Each column strobe falls with the low column field on the bus. The column field is 9 bits when `ROW13`=1 (row 13 bits) and 10 bits when `ROW13`=0 (row 12 bits), zero-padded to 13 bits.
- R3: A column strobe falls only at least `T_RCD` clocks after the row strobe fell.
- R4: The row strobe stays high for at least `T_RP` clocks before each fall.
- R5: Each row-low period lasts at least `T_RAS` clocks.
- R6: A request to the open row is accepted without a new row strobe fall. Its read data arrives `1+T_CAS` clocks after acceptance, against `T_RCD+1+T_CAS` clocks for an access from a closed row.
- R7: Each column-strobe low pulse lasts exactly `T_CAS` clocks. Both column strobes stay high for at least `T_CP` clocks between pulses.
- R8: A write lowers the lower column strobe only if `req_be[0]` is set, which writes DQ[7:0]. It lowers the upper column strobe only if `req_be[1]` is set, which writes DQ[15:8]. A read lowers both strobes.
- R9: A write's write strobe is low at least one clock before its column strobes fall, and the output enable stays high during write cycles.
- R10: A read returns the last value written to that word, with each byte merged under its enables. `rsp_valid` is high for exactly one clock and is low in the clock before.
- R11: The controller stops driving the data bus at least one clock before the output enable falls, so the bus never carries two drivers.
- R12: While `ref_grant` is high, `req_ready` is low, no row strobe falls, and an open row is closed once R5 allows.
- R13: The row strobe never stays low longer than `T_PAGE_MAX` clocks; an idle open row is closed before that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address (row above column) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = DQ[7:0] |
| rsp_data | output | 16 | Read data |
| rsp_valid | output | 1 | One-clock read data strobe |
| ref_grant | input | 1 | External refresh owns the DRAM |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_dq | inout | 16 | Bidirectional data bus |

## Verification
Read data is due `T_RCD+1+T_CAS` clocks (11 by default) after the accepting edge when the row was closed, and `1+T_CAS` clocks (5) when the row was already open. The bench decides which case applies from the row strobe level it sees just before acceptance. It samples one nanosecond after the due edge and also checks that `rsp_valid` is still low one edge earlier. Strobe intervals are checked by a bench-side DRAM model. The model counts whole clocks between strobe edges at each falling clock edge and stores written bytes from the data bus at each column strobe fall. Row/column latch values and strobe patterns are compared once the access's data edge has passed.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_PRE,
        ST_IDLE,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_CP,
        ST_OPEN
    } fpm_state_e;
endpackage

// File: rtl/fpm_addr_map.sv
`timescale 1ns/1ps
module fpm_addr_map #(
    parameter bit ROW13 = 1'b1,
    parameter int ABW   = 13,
    localparam int COL_W = ROW13 ? 9 : 10,
    localparam int ROW_W = ROW13 ? 13 : 12,
    localparam int AW    = ROW_W + COL_W
) (
    input  logic [AW-1:0]    addr,
    output logic [ROW_W-1:0] row,
    output logic [ABW-1:0]   row_bus,
    output logic [ABW-1:0]   col_bus
);
    assign row     = addr[AW-1:COL_W];
    assign col_bus = {{(ABW-COL_W){1'b0}}, addr[COL_W-1:0]};

    generate
        if (ROW_W < ABW) begin : g_row_pad
            assign row_bus = {{(ABW-ROW_W){1'b0}}, row};
        end else begin : g_row_full
            assign row_bus = row[ABW-1:0];
        end
    endgenerate
endmodule

// File: rtl/fpm_ras_age.sv
`timescale 1ns/1ps
module fpm_ras_age #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ras_n,
    output logic [W-1:0] low_cnt,
    output logic [W-1:0] high_cnt
);
    localparam logic [W-1:0] SAT = '1;

    logic [W-1:0] low_d, high_d;

    always_comb begin
        low_d  = ras_n ? '0 : ((low_cnt == SAT) ? SAT : low_cnt + 1'b1);
        high_d = ras_n ? ((high_cnt == SAT) ? SAT : high_cnt + 1'b1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            low_cnt  <= low_d;
            high_cnt <= high_d;
        end
    end
endmodule

// File: rtl/fpm_ctrl.sv
`timescale 1ns/1ps
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter bit ROW13      = 1'b1,
    parameter int T_RCD      = 6,
    parameter int T_RP       = 6,
    parameter int T_RAS      = 10,
    parameter int T_CAS      = 4,
    parameter int T_CP       = 2,
    parameter int T_PAGE_MAX = 19000,
    localparam int COL_W = ROW13 ? 9 : 10,
    localparam int ROW_W = ROW13 ? 13 : 12,
    localparam int AW    = ROW_W + COL_W,
    localparam int ABW   = 13,
    localparam int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_be,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_valid,
    input  logic          ref_grant,
    output logic          dram_ras_n,
    output logic          dram_lcas_n,
    output logic          dram_ucas_n,
    output logic          dram_we_n,
    output logic          dram_oe_n,
    output logic [ABW-1:0] dram_addr,
    inout  wire  [DW-1:0] dram_dq
);
    localparam int TSUM       = T_RCD + T_RP + T_CAS + T_CP;
    localparam int CW         = $clog2(TSUM + 1);
    localparam int AGW        = $clog2(T_PAGE_MAX + 2);
    localparam int PAGE_CLOSE = T_PAGE_MAX - (T_CAS + T_CP + 3);

    typedef struct packed {
        fpm_state_e     st;
        logic [CW-1:0]  cnt;
        logic           ras_n;
        logic           lcas_n;
        logic           ucas_n;
        logic           we_n;
        logic           oe_n;
        logic [ABW-1:0] addr;
        logic [DW-1:0]  dq_out;
        logic           dq_oe;
        logic           wr;
        logic [1:0]     be;
        logic [ABW-1:0] col;
        logic [ROW_W-1:0] row;
        logic [DW-1:0]  rsp_data;
        logic           rsp_valid;
    } regs_t;

    regs_t q, n;

    logic [ROW_W-1:0] req_row;
    logic [ABW-1:0]   row_bus, col_bus;
    logic [AGW-1:0]   low_cnt, high_cnt;
    logic             hit, page_old, close_want, accept;

    fpm_addr_map #(.ROW13(ROW13), .ABW(ABW)) u_map (
        .addr    (req_addr),
        .row     (req_row),
        .row_bus (row_bus),
        .col_bus (col_bus)
    );

    fpm_ras_age #(.W(AGW)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (q.ras_n),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt)
    );

    assign hit        = (req_row == q.row);
    assign page_old   = (low_cnt >= AGW'(PAGE_CLOSE));
    assign close_want = ref_grant || (req_valid && !hit) || page_old;
    assign req_ready  = !ref_grant &&
                        ((q.st == ST_IDLE) || ((q.st == ST_OPEN) && hit && !page_old));
    assign accept     = req_valid && req_ready;

    always_comb begin
        n = q;
        n.rsp_valid = 1'b0;
        unique case (q.st)
            ST_PRE: begin
                if (q.cnt == '0) n.st = ST_IDLE;
                else             n.cnt = q.cnt - 1'b1;
            end
            ST_IDLE: begin
                if (accept) begin
                    n.st     = ST_RCD;
                    n.ras_n  = 1'b0;
                    n.addr   = row_bus;
                    n.row    = req_row;
                    n.col    = col_bus;
                    n.wr     = req_write;
                    n.be     = req_be;
                    n.dq_out = req_wdata;
                    n.cnt    = CW'(T_RCD - 1);
                end
            end
            ST_RCD: begin
                if (q.cnt == '0) begin
                    n.st    = ST_COL;
                    n.addr  = q.col;
                    n.we_n  = !q.wr;
                    n.dq_oe = q.wr;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                n.st     = ST_CAS;
                n.lcas_n = q.wr & !q.be[0];
                n.ucas_n = q.wr & !q.be[1];
                n.oe_n   = q.wr;
                n.cnt    = CW'(T_CAS - 1);
            end
            ST_CAS: begin
                if (q.cnt == '0) begin
                    n.st     = ST_CP;
                    n.lcas_n = 1'b1;
                    n.ucas_n = 1'b1;
                    n.oe_n   = 1'b1;
                    n.we_n   = 1'b1;
                    n.cnt    = CW'(T_CP - 1);
                    if (!q.wr) begin
                        n.rsp_data  = dram_dq;
                        n.rsp_valid = 1'b1;
                    end
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            ST_CP: begin
                if (q.cnt == '0) n.st = ST_OPEN;
                else             n.cnt = q.cnt - 1'b1;
            end
            ST_OPEN: begin
                if (accept) begin
                    n.st     = ST_COL;
                    n.addr   = col_bus;
                    n.wr     = req_write;
                    n.be     = req_be;
                    n.dq_out = req_wdata;
                    n.we_n   = !req_write;
                    n.dq_oe  = req_write;
                end else if (close_want && (low_cnt >= AGW'(T_RAS))) begin
                    n.st    = ST_PRE;
                    n.ras_n = 1'b1;
                    n.dq_oe = 1'b0;
                    n.cnt   = CW'(T_RP - 1);
                end
            end
            default: n.st = ST_PRE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_PRE;
            q.cnt    <= CW'(T_RP - 1);
            q.ras_n  <= 1'b1;
            q.lcas_n <= 1'b1;
            q.ucas_n <= 1'b1;
            q.we_n   <= 1'b1;
            q.oe_n   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign dram_ras_n  = q.ras_n;
    assign dram_lcas_n = q.lcas_n;
    assign dram_ucas_n = q.ucas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_addr   = q.addr;
    assign dram_dq     = q.dq_oe ? q.dq_out : {DW{1'bz}};
    assign rsp_data    = q.rsp_data;
    assign rsp_valid   = q.rsp_valid;

    // R3: column strobe falls only after the row-to-column delay
    a_r3_rcd: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.lcas_n) || $fell(q.ucas_n)) |-> (!q.ras_n && low_cnt >= AGW'(T_RCD)));
    // R4: precharge interval before each row activation
    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ras_n) |-> (high_cnt >= AGW'(T_RP)));
    // R5: minimum row-low time
    a_r5_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ras_n) |-> (low_cnt >= AGW'(T_RAS)));
    // R13: page-mode open limit
    a_r13_page_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ras_n |-> (low_cnt <= AGW'(T_PAGE_MAX)));
    // R11: bus released one clock ahead of the output enable
    a_r11_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        !q.oe_n |-> (!q.dq_oe && !$past(q.dq_oe)));
    // R9: early write ordering and no output enable while writing
    a_r9_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(q.lcas_n) || $fell(q.ucas_n)) && !q.we_n) |-> !$past(q.we_n));
    a_r9_no_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
        !q.we_n |-> q.oe_n);
    // R12: no activation under a refresh grant
    a_r12_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ras_n) |-> !$past(ref_grant));
endmodule

// File: tb/sim_fpm_ctrl.sv
`timescale 1ns/1ps
module sim_fpm_ctrl;
    localparam int T_RCD = 6, T_RP = 6, T_RAS = 10, T_CAS = 4, T_CP = 2;
    localparam int T_PAGE_MAX = 80;
    localparam int COL_W = 9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, ref_grant;
    logic [21:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    wire         req_ready, rsp_valid;
    wire  [15:0] rsp_data;
    wire         dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n;
    wire  [12:0] dram_addr;
    wire  [15:0] dq;

    logic        model_drv;
    logic [15:0] model_val;
    assign model_drv = !dram_oe_n && dram_we_n && (!dram_lcas_n || !dram_ucas_n);
    assign dq = model_drv ? model_val : 16'hzzzz;

    always #2.5 clk = ~clk;

    fpm_ctrl #(.ROW13(1'b1), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
               .T_CAS(T_CAS), .T_CP(T_CP), .T_PAGE_MAX(T_PAGE_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .ref_grant(ref_grant), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
        .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq(dq)
    );

    int n_chk = 0, n_fail = 0;
    logic [15:0] dmem [int];
    logic [15:0] refm [int];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // DRAM model and pin-level timing monitor
    int lo_cnt, hi_cnt, cas_lo, cas_hi, ras_falls, ras_rises;
    bit p_ras, p_cas, p_we;
    logic [12:0] lat_row, lat_col;
    logic [1:0]  last_pat;

    always @(negedge clk) begin
        bit cas_low;
        int key;
        logic [15:0] cur;
        if (!rst_n) begin
            lo_cnt = 0; hi_cnt = 0; cas_lo = 0; cas_hi = 0;
            p_ras = 1; p_cas = 0; p_we = 1;
        end else begin
            cas_low = !(dram_lcas_n && dram_ucas_n);
            if (p_ras && !dram_ras_n) begin
                chk(hi_cnt >= T_RP, "R4", "row precharge clocks", hi_cnt, T_RP);
                lat_row = dram_addr;
                ras_falls++;
            end
            if (!p_ras && dram_ras_n) begin
                chk(lo_cnt >= T_RAS, "R5", "row low clocks", lo_cnt, T_RAS);
                chk(lo_cnt <= T_PAGE_MAX, "R13", "row open clocks", lo_cnt, T_PAGE_MAX);
                ras_rises++;
            end
            if (!p_cas && cas_low) begin
                chk(!dram_ras_n && lo_cnt >= T_RCD, "R3", "row-to-column clocks", lo_cnt, T_RCD);
                chk(cas_hi >= T_CP, "R7", "column precharge clocks", cas_hi, T_CP);
                chk(dram_we_n || !p_we, "R9", "write strobe lead", p_we, 0);
                if (!dram_we_n) chk(dram_oe_n, "R9", "oe during write", dram_oe_n, 1);
                lat_col  = dram_addr;
                last_pat = {dram_ucas_n, dram_lcas_n};
                key = int'({lat_row, lat_col[COL_W-1:0]});
                cur = dmem.exists(key) ? dmem[key] : 16'h0;
                if (!dram_we_n) begin
                    if (!dram_lcas_n) cur[7:0]  = dq[7:0];
                    if (!dram_ucas_n) cur[15:8] = dq[15:8];
                    dmem[key] = cur;
                end
                model_val = cur;
            end
            if (p_cas && !cas_low)
                chk(cas_lo == T_CAS, "R7", "column low clocks", cas_lo, T_CAS);
            if (!dram_oe_n)
                chk(!$isunknown(dq), "R11", "bus contention on read", dq, 0);
            lo_cnt = dram_ras_n ? 0 : (p_ras ? 1 : lo_cnt + 1);
            hi_cnt = dram_ras_n ? (p_ras ? hi_cnt + 1 : 1) : 0;
            cas_lo = cas_low ? cas_lo + 1 : 0;
            cas_hi = cas_low ? 0 : cas_hi + 1;
            p_ras = dram_ras_n; p_cas = cas_low; p_we = dram_we_n;
        end
    end

    task automatic access(input bit wr, input logic [21:0] a,
                          input logic [15:0] d, input logic [1:0] be);
        bit hit;
        int lat, falls0;
        logic [15:0] exp;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        hit = !dram_ras_n;
        falls0 = ras_falls;
        @(posedge clk);
        #1 req_valid = 0;
        lat = hit ? 1 + T_CAS : T_RCD + 1 + T_CAS;
        repeat (lat - 1) @(posedge clk);
        #1;
        chk(!rsp_valid, "R10", "rsp_valid before due", rsp_valid, 0);
        @(posedge clk);
        #1;
        if (!wr) begin
            exp = refm.exists(int'(a)) ? refm[int'(a)] : 16'h0;
            chk(rsp_valid === 1'b1, "R6", "read due clock", rsp_valid, 1);
            chk(rsp_data === exp, "R10", "read data", rsp_data, exp);
            chk(last_pat == 2'b00, "R8", "read strobes", last_pat, 0);
        end else begin
            exp = refm.exists(int'(a)) ? refm[int'(a)] : 16'h0;
            if (be[0]) exp[7:0]  = d[7:0];
            if (be[1]) exp[15:8] = d[15:8];
            refm[int'(a)] = exp;
            chk(last_pat == ~be, "R8", "write strobes", last_pat, ~be);
        end
        chk(lat_row == {a[21:COL_W]}, "R2", "row address", lat_row, a[21:COL_W]);
        chk(lat_col == 13'(a[COL_W-1:0]), "R2", "column address", lat_col, a[COL_W-1:0]);
        if (hit) chk(ras_falls == falls0, "R6", "no activation on hit", ras_falls, falls0);
    endtask

    function automatic logic [21:0] pick_addr(input int r, input int c);
        logic [12:0] rows [4];
        rows[0] = 13'h0000; rows[1] = 13'h0001; rows[2] = 13'h1FFF; rows[3] = 13'h00AA;
        return {rows[r], 9'(c)};
    endfunction

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int rise0;
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0;
        req_wdata = '0; req_be = 2'b11; ref_grant = 0;
        repeat (4) @(negedge clk);
        #1;
        chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n,
            "R1", "strobes in reset", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n}, 5'h1f);
        chk(dq === 16'hzzzz, "R1", "bus released in reset", dq, 16'hffff);
        chk(!rsp_valid && !req_ready, "R1", "handshake in reset", {rsp_valid, req_ready}, 0);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(!req_ready && dram_ras_n, "R1", "ready after reset", req_ready, 0);

        // byte-lane merging (R8, R10)
        access(1, pick_addr(0, 5), 16'hAAAA, 2'b11);
        access(1, pick_addr(0, 5), 16'h5566, 2'b01);
        access(0, pick_addr(0, 5), 16'h0, 2'b11);
        access(1, pick_addr(0, 5), 16'h7700, 2'b10);
        access(0, pick_addr(0, 5), 16'h0, 2'b11);
        access(0, pick_addr(2, 511), 16'h0, 2'b11);

        void'($urandom(32'h1F3A));
        for (int i = 0; i < 400; i++) begin
            access($urandom_range(0, 1), pick_addr($urandom_range(0, 3), $urandom_range(0, 511)),
                   16'($urandom), 2'($urandom_range(1, 3)));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        // R12: refresh grant closes the row and blocks requests
        access(0, pick_addr(1, 7), 16'h0, 2'b11);
        @(negedge clk);
        ref_grant = 1; req_valid = 1; req_write = 0; req_addr = pick_addr(1, 7);
        rise0 = ras_falls;
        repeat (20) @(negedge clk);
        #1;
        chk(!req_ready, "R12", "ready under grant", req_ready, 0);
        chk(dram_ras_n, "R12", "row closed under grant", dram_ras_n, 1);
        chk(ras_falls == rise0, "R12", "no activation under grant", ras_falls, rise0);
        @(negedge clk);
        ref_grant = 0; req_valid = 0;

        // R13: idle open row is closed before the page limit
        access(0, pick_addr(3, 9), 16'h0, 2'b11);
        repeat (100) @(negedge clk);
        #1;
        chk(dram_ras_n, "R13", "idle row closed", dram_ras_n, 1);
        rise0 = ras_rises;
        for (int i = 0; i < 30; i++) access(0, pick_addr(3, i), 16'h0, 2'b11);
        chk(ras_rises > rise0, "R13", "streaming row closed", ras_rises, rise0 + 1);

        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule